// File: doc/BRIEF.md
# Linear/Circular Effective Address Generator

This block forms the effective address of a load or store for one address unit of a two-sided data path. A request carries a base register, named by its side (A or B) and its index, together with the base register's current value. It also carries an unsigned constant offset, an access-size code and an update form. The block returns the address the memory access uses and the new value to write back into the base register.

Each base register works in linear or circular mode. Linear mode is ordinary 32-bit arithmetic. Circular mode keeps the pointer inside an aligned block of 2^N bytes: the adder may change only the low N bits, and the bits above them pass through from the base.

Circular mode is open only to registers 4 to 7 of each side. A small mode register selects it for each of these eight registers. The mode register is loaded through a plain write port. The results appear on registered outputs one clock after the request.

Top module: `lincirc_agen`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` is 0 and the mode register holds zero, so every base register works in linear mode.
- R2: A request presented with `req_valid`=1 at a rising edge produces `out_valid`=1 and its results exactly one clock later. A cycle without a request produces `out_valid`=0 one clock later.
- R3: The offset is scaled by the size code before it is added: 00 multiplies by 1 (byte), 01 by 2 (halfword), 10 by 4 (word), and the code 11 is treated as word (×4).
- R4: `req_op` 00 is pre-increment, 01 pre-decrement, 10 post-increment and 11 post-decrement. `out_base` is always the updated base. `out_addr` equals `out_base` for the pre forms and the original base for the post forms.
- R5: With `req_long`=0 only `req_off[4:0]` is used, zero-extended, and bits [14:5] are ignored. With `req_long`=1 all 15 bits of `req_off` are used, which is legal only when `req_unit`=1 (second unit).
- R6: A request with `req_long`=1 and `req_unit`=0 is illegal. It gives `out_illegal`=1, and both `out_addr` and `out_base` equal the original base.
- R7: In linear mode the update is a full 32-bit add or subtract, wrapping modulo 2^32.
- R8: Only `req_idx` 4 to 7 on either side (`req_bank` 0 = A, 1 = B) can be circular. Every other index is linear, whatever the mode register holds.
- R9: Mode register layout: the field for A(4+k) is at bits [2k+1:2k] and the field for B(4+k) at bits [2k+9:2k+8]. Field value 00 is linear, 01 is circular with size field 0 (bits [20:16]), 10 is circular with size field 1 (bits [25:21]), and 11 is linear.
- R10: In circular mode with size value N, only the low N bits of the base change, giving a modulo-2^N update. The bits above N are copied from the base unchanged.
- R11: A mode-register write affects requests from the next cycle onward. A request in the same cycle as the write uses the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Mode register write enable |
| cfg_wdata | input | 26 | Mode register write data |
| req_valid | input | 1 | Request present |
| req_unit | input | 1 | Address unit: 0 first, 1 second |
| req_bank | input | 1 | Base register side: 0 A, 1 B |
| req_idx | input | 4 | Base register index on its side |
| req_base | input | 32 | Current base register value |
| req_long | input | 1 | Use the 15-bit offset form |
| req_off | input | 15 | Unsigned offset constant |
| req_size | input | 2 | Access size code |
| req_op | input | 2 | Update form |
| out_valid | output | 1 | Result valid |
| out_addr | output | 32 | Effective address for the access |
| out_base | output | 32 | Updated base value |
| out_illegal | output | 1 | Long offset requested on first unit |

## Verification
Every address result is due on the rising edge after the request. The bench drives inputs at the falling edge and computes the expected result from its own model at that moment. It then waits for the next rising edge and compares all outputs one time unit later. A mode-register write changes the model only after the comparison of the cycle in which the write was made. This matches the one-cycle delay in R11, so a request issued together with a write is checked against the old mode.

// File: rtl/agen_pkg.sv
package agen_pkg;

  typedef enum logic [1:0] {
    OP_PRE_INC  = 2'b00,
    OP_PRE_DEC  = 2'b01,
    OP_POST_INC = 2'b10,
    OP_POST_DEC = 2'b11
  } agen_op_e;

  typedef enum logic [1:0] {
    AM_LINEAR = 2'b00,
    AM_CIRC0  = 2'b01,
    AM_CIRC1  = 2'b10,
    AM_RSVD   = 2'b11
  } agen_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } agen_size_e;

  function automatic logic [1:0] size_shift(input agen_size_e sz);
    case (sz)
      SZ_BYTE: size_shift = 2'd0;
      SZ_HALF: size_shift = 2'd1;
      default: size_shift = 2'd2;
    endcase
  endfunction

  function automatic logic is_circ(input agen_mode_e m);
    is_circ = (m == AM_CIRC0) || (m == AM_CIRC1);
  endfunction

endpackage

// File: rtl/agen_modereg.sv
module agen_modereg
  import agen_pkg::*;
#(
  parameter int IDX_W         = 4,
  parameter int ELIG_LO       = 4,
  parameter int ELIG_PER_BANK = 4,
  parameter int SIZE_FW       = 5,
  parameter int CFG_W         = 4 * ELIG_PER_BANK + 2 * SIZE_FW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [CFG_W-1:0]   wdata,
  input  logic               bank,
  input  logic [IDX_W-1:0]   idx,
  output logic               circ,
  output logic [SIZE_FW-1:0] nbits
);

  localparam int NFLD     = 2 * ELIG_PER_BANK;
  localparam int SEL_W    = $clog2(ELIG_PER_BANK);
  localparam int SIZE_LSB = 2 * NFLD;

  logic [CFG_W-1:0]   cfg_q;
  agen_mode_e         mode_f [NFLD];
  logic [SIZE_FW-1:0] size_f [2];

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else if (we) cfg_q <= wdata;
  end

  for (genvar g = 0; g < NFLD; g++) begin : g_mode
    assign mode_f[g] = agen_mode_e'(cfg_q[2*g +: 2]);
  end

  for (genvar s = 0; s < 2; s++) begin : g_size
    assign size_f[s] = cfg_q[SIZE_LSB + s*SIZE_FW +: SIZE_FW];
  end

  logic [IDX_W-1:0] rel;
  logic             elig;
  agen_mode_e       sel_mode;

  always_comb begin
    rel      = idx - IDX_W'(ELIG_LO);
    elig     = (idx >= IDX_W'(ELIG_LO)) && (rel < IDX_W'(ELIG_PER_BANK));
    sel_mode = mode_f[{bank, rel[SEL_W-1:0]}];
    circ     = elig && is_circ(sel_mode);
    nbits    = (sel_mode == AM_CIRC1) ? size_f[1] : size_f[0];
  end

endmodule

// File: rtl/agen_offset.sv
module agen_offset
  import agen_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SHORT_W = 5,
  parameter int LONG_W  = 15
) (
  input  logic              long_sel,
  input  logic [LONG_W-1:0] off,
  input  logic [1:0]        size,
  input  logic              dec,
  output logic [ADDR_W-1:0] delta
);

  logic [LONG_W-1:0] mag;
  logic [ADDR_W-1:0] scaled;

  always_comb begin
    mag    = long_sel ? off : LONG_W'(off[SHORT_W-1:0]);
    scaled = ADDR_W'(mag) << size_shift(agen_size_e'(size));
    delta  = dec ? (~scaled + ADDR_W'(1)) : scaled;
  end

endmodule

// File: rtl/agen_wrap.sv
module agen_wrap #(
  parameter int ADDR_W = 32,
  parameter int NB_W   = 5
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] delta,
  input  logic              circ,
  input  logic [NB_W-1:0]   nbits,
  output logic [ADDR_W-1:0] next
);

  logic [ADDR_W-1:0] sum;
  logic [ADDR_W-1:0] live;

  assign sum = base + delta;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    assign live[i] = !circ || (32'(i) < 32'(nbits));
    assign next[i] = live[i] ? sum[i] : base[i];
  end

endmodule

// File: rtl/lincirc_agen.sv
module lincirc_agen
  import agen_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int REGS_PER_BANK = 16,
  parameter int IDX_W         = $clog2(REGS_PER_BANK),
  parameter int ELIG_LO       = 4,
  parameter int ELIG_PER_BANK = 4,
  parameter int SIZE_FW       = 5,
  parameter int SHORT_W       = 5,
  parameter int LONG_W        = 15,
  parameter int CFG_W         = 4 * ELIG_PER_BANK + 2 * SIZE_FW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req_valid,
  input  logic              req_unit,
  input  logic              req_bank,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [ADDR_W-1:0] req_base,
  input  logic              req_long,
  input  logic [LONG_W-1:0] req_off,
  input  logic [1:0]        req_size,
  input  logic [1:0]        req_op,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [ADDR_W-1:0] out_base,
  output logic              out_illegal
);

  logic               circ;
  logic [SIZE_FW-1:0] nbits;
  logic [ADDR_W-1:0]  delta;
  logic [ADDR_W-1:0]  next_base;
  agen_op_e           op;
  logic               dec;
  logic               post;
  logic               illegal;

  assign op      = agen_op_e'(req_op);
  assign dec     = (op == OP_PRE_DEC) || (op == OP_POST_DEC);
  assign post    = (op == OP_POST_INC) || (op == OP_POST_DEC);
  assign illegal = req_long && !req_unit;

  agen_modereg #(
    .IDX_W(IDX_W), .ELIG_LO(ELIG_LO), .ELIG_PER_BANK(ELIG_PER_BANK),
    .SIZE_FW(SIZE_FW), .CFG_W(CFG_W)
  ) u_mode (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .bank(req_bank), .idx(req_idx), .circ(circ), .nbits(nbits)
  );

  agen_offset #(
    .ADDR_W(ADDR_W), .SHORT_W(SHORT_W), .LONG_W(LONG_W)
  ) u_off (
    .long_sel(req_long), .off(req_off), .size(req_size), .dec(dec), .delta(delta)
  );

  agen_wrap #(
    .ADDR_W(ADDR_W), .NB_W(SIZE_FW)
  ) u_wrap (
    .base(req_base), .delta(delta), .circ(circ), .nbits(nbits), .next(next_base)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_addr    <= '0;
      out_base    <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_illegal <= illegal;
        if (illegal) begin
          out_addr <= req_base;
          out_base <= req_base;
        end else begin
          out_base <= next_base;
          out_addr <= post ? req_base : next_base;
        end
      end
    end
  end

endmodule

// File: rtl/lincirc_agen_chk.sv
module lincirc_agen_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_unit,
  input logic              req_long,
  input logic [ADDR_W-1:0] req_base,
  input logic [1:0]        req_op,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr,
  input logic [ADDR_W-1:0] out_base,
  input logic              out_illegal
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);

  // R2
  idle_latency_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);

  // R4
  post_addr_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_op[1] |=> out_addr == $past(req_base));

  // R4
  pre_addr_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_op[1] |=> out_addr == out_base);

  // R6
  illegal_flag_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_long && !req_unit |=> out_illegal && out_base == $past(req_base));

  // R5
  legal_unit_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_unit |=> !out_illegal);

endmodule

bind lincirc_agen lincirc_agen_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/lincirc_agen_tb.sv
module lincirc_agen_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [25:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_unit = 1'b0;
  logic        req_bank = 1'b0;
  logic [3:0]  req_idx = '0;
  logic [31:0] req_base = '0;
  logic        req_long = 1'b0;
  logic [14:0] req_off = '0;
  logic [1:0]  req_size = '0;
  logic [1:0]  req_op = '0;
  logic        out_valid;
  logic [31:0] out_addr;
  logic [31:0] out_base;
  logic        out_illegal;

  int n_checks = 0;
  int n_errors = 0;
  logic [25:0] m_cfg = '0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lincirc_agen u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_unit(req_unit), .req_bank(req_bank),
    .req_idx(req_idx), .req_base(req_base), .req_long(req_long),
    .req_off(req_off), .req_size(req_size), .req_op(req_op),
    .out_valid(out_valid), .out_addr(out_addr), .out_base(out_base),
    .out_illegal(out_illegal)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [25:0] mk_cfg(input int slot, input int mode,
                                         input int n0, input int n1);
    logic [25:0] c;
    c = '0;
    if (slot >= 0) c[2*slot +: 2] = 2'(mode);
    c[20:16] = 5'(n0);
    c[25:21] = 5'(n1);
    return c;
  endfunction

  // Behavioural reference: computes results from the requirements.
  task automatic model(output logic [31:0] ea, output logic [31:0] nb,
                       output logic ill);
    longint mag, d, sum;
    int mode, n, slot;
    longint mask;
    mag = req_long ? longint'(req_off) : longint'(req_off[4:0]);
    case (req_size)
      2'd0: d = mag;
      2'd1: d = mag * 2;
      default: d = mag * 4;
    endcase
    if (req_op[0]) d = -d;
    sum = longint'(req_base) + d;
    nb = sum[31:0];
    mode = 0;
    if (req_idx >= 4 && req_idx <= 7) begin
      slot = (req_bank ? 4 : 0) + int'(req_idx) - 4;
      mode = int'(m_cfg[2*slot +: 2]);
    end
    if (mode == 1 || mode == 2) begin
      n = (mode == 1) ? int'(m_cfg[20:16]) : int'(m_cfg[25:21]);
      mask = (longint'(1) << n) - 1;
      nb = (req_base & ~mask[31:0]) | (sum[31:0] & mask[31:0]);
    end
    ill = req_long && !req_unit;
    if (ill) nb = req_base;
    ea = (req_op[1] || ill) ? req_base : nb;
  endtask

  task automatic tick(input string tag);
    logic [31:0] e_ea, e_nb;
    logic e_ill;
    logic e_v;
    e_v = req_valid;
    model(e_ea, e_nb, e_ill);
    @(posedge clk);
    #1;
    chk(tag, "out_valid", {31'b0, out_valid}, {31'b0, e_v});
    if (e_v) begin
      chk(tag, "out_addr", out_addr, e_ea);
      chk(tag, "out_base", out_base, e_nb);
      chk(tag, "out_illegal", {31'b0, out_illegal}, {31'b0, e_ill});
    end
    if (cfg_we) m_cfg = cfg_wdata;
    @(negedge clk);
    req_valid = 1'b0;
    cfg_we = 1'b0;
  endtask

  task automatic req(input string tag, input bit unit, input bit bank,
                     input int idx, input logic [31:0] base, input bit lng,
                     input int off, input int size, input int op);
    req_valid = 1'b1;
    req_unit  = unit;
    req_bank  = bank;
    req_idx   = 4'(idx);
    req_base  = base;
    req_long  = lng;
    req_off   = 15'(off);
    req_size  = 2'(size);
    req_op    = 2'(op);
    tick(tag);
  endtask

  task automatic wcfg(input logic [25:0] v);
    cfg_we = 1'b1;
    cfg_wdata = v;
    tick("R11 cfg write");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset", "out_valid", {31'b0, out_valid}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    // R1: eligible A4 is linear after reset
    req("R1 linear after reset", 1'b0, 1'b0, 4, 32'h0000_00F0, 1'b0, 5, 2, 0);
    // R2: idle cycle gives no valid
    tick("R2 idle");
    // R3: size codes
    for (int s = 0; s < 4; s++)
      req("R3 size scaling", 1'b0, 1'b1, 2, 32'h0000_1000, 1'b0, 3, s, 0);
    // R4: four update forms
    for (int o = 0; o < 4; o++)
      req("R4 op form", 1'b1, 1'b0, 9, 32'h0000_2000, 1'b0, 7, 1, o);
    // R5: short form ignores high offset bits, long form uses all 15
    req("R5 short form", 1'b0, 1'b0, 1, 32'h0000_0100, 1'b0, 15'h7FE3, 0, 0);
    req("R5 long form", 1'b1, 1'b1, 3, 32'h0001_0000, 1'b1, 15'h1234, 2, 2);
    // R6: long form on first unit
    req("R6 illegal long", 1'b0, 1'b0, 5, 32'hABCD_0000, 1'b1, 15'h0400, 2, 0);
    // R7: linear 32-bit wrap both directions
    req("R7 linear wrap up", 1'b0, 1'b0, 0, 32'hFFFF_FFFC, 1'b0, 2, 2, 0);
    req("R7 linear wrap down", 1'b0, 1'b1, 0, 32'h0000_0004, 1'b0, 3, 2, 1);
    // R11: write A5 circular N=4 with a same-cycle request to A5
    cfg_we = 1'b1;
    cfg_wdata = mk_cfg(1, 1, 4, 8);
    req("R11 old mode same cycle", 1'b0, 1'b0, 5, 32'h1000_000C, 1'b0, 2, 2, 0);
    // R10: now circular
    req("R10 circular wrap up", 1'b0, 1'b0, 5, 32'h1000_000C, 1'b0, 2, 2, 0);
    req("R10 circular wrap down", 1'b0, 1'b0, 5, 32'h1000_0002, 1'b0, 1, 2, 1);
    req("R10 circular post", 1'b0, 1'b0, 5, 32'h1000_000E, 1'b0, 4, 0, 2);
    // R9: B7 uses size field 1
    wcfg(mk_cfg(7, 2, 4, 8));
    req("R9 B7 size1", 1'b1, 1'b1, 7, 32'h2000_01F8, 1'b1, 15'h0010, 0, 0);
    req("R9 A5 cleared linear", 1'b0, 1'b0, 5, 32'h1000_000C, 1'b0, 2, 2, 0);
    // R9: reserved code 11 is linear
    wcfg(mk_cfg(2, 3, 4, 4));
    req("R9 reserved mode", 1'b0, 1'b0, 6, 32'h3000_000E, 1'b0, 4, 0, 0);
    // R8: all fields circular, ineligible indices stay linear
    wcfg(26'h3FF_5555 & 26'h03F_5555 | mk_cfg(-1, 0, 3, 3));
    req("R8 A3 linear", 1'b0, 1'b0, 3, 32'h0000_0007, 1'b0, 1, 0, 0);
    req("R8 B8 linear", 1'b0, 1'b1, 8, 32'h0000_0007, 1'b0, 1, 0, 0);
    req("R8 A4 circular", 1'b0, 1'b0, 4, 32'h0000_0007, 1'b0, 1, 0, 0);
    req("R8 B4 circular", 1'b0, 1'b1, 4, 32'h0000_0007, 1'b0, 1, 0, 0);
    // Mixed traffic with occasional mode writes
    for (int k = 0; k < 400; k++) begin
      if (k % 37 == 0) begin
        cfg_we = 1'b1;
        cfg_wdata = 26'($urandom);
      end
      if (k % 5 == 4) tick("R2 mixed idle");
      else req("R10 mixed traffic", 1'($urandom), 1'($urandom), int'($urandom % 16),
               $urandom, 1'($urandom), int'($urandom % 32768),
               int'($urandom % 4), int'($urandom % 4));
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule